// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit control and status word in a bridge's control space. It records why the most recent system reset happened and lets software ask for a soft reset. Only the top five bits carry meaning. Three of them are cause flags that software clears by writing ones. Two are request bits that a written one sets.

When software writes a one to either request bit, the block sends a one-cycle request to the system reset generator. The block also counts the system resets it sees in a saturating counter. This lets it tell the first reset after power-up, or after a soft power-on request, from any later reset. Only that first reset loads the power-on flag.

The block sits on a simple register interface with a combinational read and a single-cycle write strobe. Reset events and push-button events come in as single-cycle strobes from logic outside the block.

Top module: `rst_ctl_status`

## Requirements
- R1: After the hardware power-on input `por_n` is released, the register reads 0x80000000 (only bit 31 set), `sys_rst_req_o` is low, and the reset counter is zero.
- R2: Bits 26..0 always read zero. Write data is masked to 0xF8000000 before any other rule applies.
- R3: Bits 31 (power-on flag), 28 (button power-on flag) and 27 (button XIR flag) are write-one-to-clear. Writing zero to them leaves them unchanged.
- R4: Bits 30 (soft power-on request) and 29 (soft XIR request) are set by a written one. A written zero leaves them unchanged.
- R5: The register answers only at the upper word of its 8-byte slot (address bit 2 set, address bits 1..0 ignored). The lower word and every other address read zero, and writes to them change nothing.
- R6: A write with bit 30 set clears the reset counter. In the cycle after the write edge, `sys_rst_req_o` is high for exactly one cycle.
- R7: A write with bit 29 set and bit 30 clear raises the same one-cycle request and leaves the counter unchanged.
- R8: On a reset event (`rst_evt_i`) with the counter at zero, the register is loaded with 0x80000000. With the counter nonzero, the register is unchanged. The counter increments on every reset event.
- R9: The counter saturates at its maximum value. Any number of reset events without a soft power-on write never reloads the power-on flag.
- R10: Button event strobes set bit 28 (power-on button) or bit 27 (XIR button). A set takes priority over a same-cycle write-one-to-clear of that bit.
- R11: A register write in the same cycle as a reset event is ignored: no bit changes from it, no request pulse, no counter clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low hardware power-on reset; zeroes the counter |
| rst_evt_i | input | 1 | One-cycle strobe: a sequenced system reset took place |
| btn_por_evt_i | input | 1 | One-cycle strobe: power-on button reset seen |
| btn_xir_evt_i | input | 1 | One-cycle strobe: XIR button reset seen |
| addr_i | input | ADDR_W | Byte address into the control space |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The writes cover ones and zeros on each bit class, so that clearing bits, setting bits and ignored bits are each distinguished. Writes go to the live word, the dead lower word and an unrelated address, to separate decode errors from masking errors. Reset-event sequences are placed after a soft power-on write, after a soft XIR write, and after a run of more events than the counter can hold. The flag reload then shows whether the counter was cleared, left alone, or wrapped. Same-cycle collisions of a button set with a clear, and of a reset event with a write, fix the priority order.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [REG_W-1:0] MASK_DEF  = 32'hF800_0000;
  localparam logic [REG_W-1:0] MASK_W1C  = 32'h9800_0000;
  localparam logic [REG_W-1:0] MASK_SET  = 32'h6000_0000;
  localparam logic [REG_W-1:0] FLAG_PWR  = 32'h8000_0000;
  localparam int unsigned BIT_SPWR = 30;
  localparam int unsigned BIT_SXIR = 29;
  localparam int unsigned BIT_BPWR = 28;
  localparam int unsigned BIT_BXIR = 27;
endpackage

// File: rtl/rcs_decode.sv
module rcs_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic slot_match;
  logic unused_lo;

  assign slot_match = (addr_i[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
  assign hit_o      = slot_match & addr_i[2];
  assign unused_lo  = ^addr_i[1:0];
endmodule

// File: rtl/rcs_sat_cnt.sv
module rcs_sat_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic inc_i,
  input  logic clr_i,
  output logic zero_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc_i) begin
      cnt_en = 1'b1;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rcs_pulse.sv
module rcs_pulse (
  input  logic clk,
  input  logic por_n,
  input  logic fire_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pulse_q <= 1'b0;
    else        pulse_q <= fire_i;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rst_ctl_status.sv
module rst_ctl_status
  import rcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_evt_i,
  input  logic              btn_por_evt_i,
  input  logic              btn_xir_evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sys_rst_req_o
);
  logic             hit;
  logic             wr_hit;
  logic             wr_live;
  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] csr_q, csr_d;
  logic             csr_en;
  logic             cnt_zero;
  logic             req_fire;
  logic             cnt_clr;

  rcs_decode #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign wr_hit   = wr_en_i & hit;
  assign wr_live  = wr_hit & ~rst_evt_i;
  assign wmask    = wdata_i & MASK_DEF;
  assign req_fire = wr_live & (wmask[BIT_SPWR] | wmask[BIT_SXIR]);
  assign cnt_clr  = wr_live & wmask[BIT_SPWR];

  rcs_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .por_n  (por_n),
    .inc_i  (rst_evt_i),
    .clr_i  (cnt_clr),
    .zero_o (cnt_zero)
  );

  rcs_pulse u_req (
    .clk     (clk),
    .por_n   (por_n),
    .fire_i  (req_fire),
    .pulse_o (sys_rst_req_o)
  );

  always_comb begin
    csr_d = csr_q;
    if (rst_evt_i) begin
      if (cnt_zero) csr_d = FLAG_PWR;
    end else if (wr_hit) begin
      csr_d = (csr_q & ~(wmask & MASK_W1C)) | (wmask & MASK_SET);
    end
    if (btn_por_evt_i) csr_d[BIT_BPWR] = 1'b1;
    if (btn_xir_evt_i) csr_d[BIT_BXIR] = 1'b1;
    csr_en = rst_evt_i | wr_hit | btn_por_evt_i | btn_xir_evt_i;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      csr_q <= FLAG_PWR;
    else if (csr_en) csr_q <= csr_d & MASK_DEF;
  end

  assign rdata_o = hit ? csr_q : '0;
endmodule

// File: rtl/rst_ctl_status_chk.sv
module rst_ctl_status_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_evt_i,
  input logic              btn_por_evt_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wdata_i,
  input logic              sys_rst_req_o,
  input logic [31:0]       csr
);
  logic wr_at_reg;
  assign wr_at_reg = wr_en_i && (addr_i[ADDR_W-1:2] == {BASE[ADDR_W-1:3], 1'b1});

  // R2: undefined bits stay zero
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
    csr[26:0] == 27'd0);

  // R3: written one clears the power-on flag
  p_w1c_r3: assert property (@(posedge clk) disable iff (!por_n)
    (wr_at_reg && wdata_i[31] && !rst_evt_i) |=> !csr[31]);

  // R4: written one sets the soft power-on request
  p_set_r4: assert property (@(posedge clk) disable iff (!por_n)
    (wr_at_reg && wdata_i[30] && !rst_evt_i) |=> csr[30]);

  // R6: a request pulse always follows a request write
  p_req_cause_r6: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req_o |-> $past(wr_at_reg && !rst_evt_i && (wdata_i[30] || wdata_i[29])));

  // R10: button set lands
  p_btn_r10: assert property (@(posedge clk) disable iff (!por_n)
    btn_por_evt_i |=> csr[28]);

  // R11: no request after a reset event
  p_noreq_r11: assert property (@(posedge clk) disable iff (!por_n)
    rst_evt_i |=> !sys_rst_req_o);
endmodule

bind rst_ctl_status rst_ctl_status_chk #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .rst_evt_i     (rst_evt_i),
  .btn_por_evt_i (btn_por_evt_i),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .wdata_i       (wdata_i),
  .sys_rst_req_o (sys_rst_req_o),
  .csr           (csr_q)
);

// File: tb/sim_rst_ctl_status.sv
module sim_rst_ctl_status;
  localparam logic [15:0] REG_A = 16'hF024;
  localparam logic [15:0] LOW_A = 16'hF020;
  localparam logic [15:0] OTH_A = 16'hF028;

  logic        clk = 1'b0;
  logic        por_n, rst_evt, btn_por, btn_xir, wr_en;
  logic [15:0] addr;
  logic [31:0] wdata, rdata;
  logic        req;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  rst_ctl_status u0 (
    .clk(clk), .por_n(por_n), .rst_evt_i(rst_evt), .btn_por_evt_i(btn_por),
    .btn_xir_evt_i(btn_xir), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .sys_rst_req_o(req)
  );

  // {addr, wdata, expected register, expected request}
  localparam logic [80:0] VEC [7] = '{
    {REG_A, 32'h0000_FFFF, 32'h8000_0000, 1'b0},  // R2
    {REG_A, 32'h2000_0000, 32'hA000_0000, 1'b1},  // R4 R7
    {REG_A, 32'h0000_0000, 32'hA000_0000, 1'b0},  // R4
    {REG_A, 32'h8000_0000, 32'h2000_0000, 1'b0},  // R3
    {LOW_A, 32'hFFFF_FFFF, 32'h2000_0000, 1'b0},  // R5
    {REG_A, 32'h4000_0000, 32'h6000_0000, 1'b1},  // R6
    {REG_A, 32'h9800_0000, 32'h6000_0000, 1'b0}   // R3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(output logic [31:0] v);
    addr = REG_A;
    #0.5;
    v = rdata;
  endtask

  task automatic evt;
    @(negedge clk);
    rst_evt = 1'b1;
    @(negedge clk);
    rst_evt = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [31:0] v;
    por_n = 1'b0; rst_evt = 0; btn_por = 0; btn_xir = 0; wr_en = 0;
    addr = REG_A; wdata = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd_reg(v);
    chk("R1 reset value", v, 32'h8000_0000);
    chk("R1 request low", {31'd0, req}, 32'd0);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][80:65], VEC[i][64:33]);
      chk("R4/R6/R7 request vector", {31'd0, req}, {31'd0, VEC[i][0]});
      rd_reg(v);
      chk("R2/R3/R4/R5 register vector", v, VEC[i][32:1]);
    end

    addr = LOW_A; #0.5;
    chk("R5 lower word reads zero", rdata, 32'd0);
    addr = OTH_A; #0.5;
    chk("R5 other address reads zero", rdata, 32'd0);

    // counter zero after soft power-on write: flag reloads
    evt(); rd_reg(v);
    chk("R8 zero counter loads flag", v, 32'h8000_0000);
    wr(REG_A, 32'h8000_0000);
    evt(); rd_reg(v);
    chk("R8 nonzero counter leaves register", v, 32'h0000_0000);

    wr(REG_A, 32'h2000_0000);
    chk("R7 xir request pulse", {31'd0, req}, 32'd1);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", {31'd0, req}, 32'd0);
    evt(); rd_reg(v);
    chk("R7 counter unchanged by xir", v, 32'h2000_0000);

    wr(REG_A, 32'h4000_0000);
    evt(); rd_reg(v);
    chk("R6 counter cleared by soft power-on", v, 32'h8000_0000);

    @(negedge clk); btn_por = 1'b1;
    @(negedge clk); btn_por = 1'b0; rd_reg(v);
    chk("R10 button power-on flag", v, 32'h9000_0000);
    @(negedge clk); btn_xir = 1'b1;
    @(negedge clk); btn_xir = 1'b0; rd_reg(v);
    chk("R10 button xir flag", v, 32'h9800_0000);
    @(negedge clk); btn_por = 1'b1; addr = REG_A; wdata = 32'h1000_0000; wr_en = 1'b1;
    @(negedge clk); btn_por = 1'b0; wr_en = 1'b0; rd_reg(v);
    chk("R10 set beats clear", v, 32'h9800_0000);
    wr(REG_A, 32'h1800_0000); rd_reg(v);
    chk("R3 clear button flags", v, 32'h8000_0000);

    @(negedge clk); rst_evt = 1'b1; addr = REG_A; wdata = 32'hC000_0000; wr_en = 1'b1;
    @(negedge clk); rst_evt = 1'b0; wr_en = 1'b0; rd_reg(v);
    chk("R11 write ignored on reset event", v, 32'h8000_0000);
    chk("R11 no request", {31'd0, req}, 32'd0);

    wr(REG_A, 32'h8000_0000);
    for (int k = 0; k < 20; k++) evt();
    rd_reg(v);
    chk("R9 saturated counter never reloads", v, 32'h0000_0000);

    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    evt(); rd_reg(v);
    chk("R1 power-on zeroes counter", v, 32'h8000_0000);

    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule